// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

This core reorders the byte channels of a time-division multiplexed frame. Every clock cycle carries one time slot. The byte presented on the input port during slot s belongs to input channel s. The byte leaving on the output port during slot m belongs to output channel m. A frame holds 32, 64 or 128 slots, depending on the selected line rate (2.048, 4.096 or 8.192 Mb/s). The core wraps its slot counter at the end of each frame. An external frame pulse can force it back to slot 0.

Incoming bytes are stored in three rotating data banks, one bank per frame. A host loads a connection table with one entry per output channel. Each entry names the source input channel and selects one of two delay modes:
- **Variable mode** gives the shortest path. The output carries the newest copy of the source byte that was stored at least three slots earlier.
- **Constant mode** keeps whole frames intact. The output reads the bank written exactly two frames before.

Host edits go into a shadow copy of the table. The shadow copy is moved into service once per frame, just before the first output slot of the next frame is fetched. This means a frame is never switched with a mixture of old and new entries.

Top module: `tsi_core`

## Requirements
- R1: `rate_sel` sets the frame length N: 0 gives 32, 1 gives 64, 2 or 3 gives 128. `slot_idx` counts 0, 1, … N-1 once per cycle and then returns to 0. The input byte of slot s is channel s. `out_byte` during slot m is output channel m.
- R2: During and right after a synchronous active-low reset:
  - `slot_idx` is 0 and `out_byte` is 0.
  - All stored bytes read as 0.
  - Every connection entry selects source channel 0 in variable mode.
- R3: In variable mode, when output channel m is at least n+3 (n is the source channel), the byte leaves in the same frame, m-n slots after it arrived.
- R4: In variable mode, when m equals n, n+1 or n+2, the byte leaves in the following frame, N+(m-n) slots after it arrived.
- R5: In variable mode, when m is less than n, the delay is N-(n-m) slots if that is at least 3. Otherwise it is 2N-(n-m) slots.
- R6: In constant mode, a byte arriving in frame k at slot n leaves in frame k+2 at slot m, which is a delay of 2N+m-n slots. This holds for every (n, m) pair.
- R7: A connection write has these fields:
  - `cm_wr_chan`: the output channel.
  - `cm_wr_src`: the source channel.
  - `cm_wr_const`: the mode bit, where 1 means constant and 0 means variable.

  A write made at a slot up to N-4 does not change the current frame's outputs. It takes effect from slot 0 of the next frame. A write made at slots N-3 to N-1 takes effect one frame later.
- R8: When `frame_pulse` is high at a clock edge, the slot after that edge is slot 0 and the data-bank rotation advances, just as at a natural frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one time slot per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Frame length select (0: 32, 1: 64, 2/3: 128 slots) |
| frame_pulse | input | 1 | Forces the next slot to 0 and starts a new frame |
| in_byte | input | 8 | Byte of the input channel equal to the current slot |
| cm_wr_en | input | 1 | Connection table write strobe |
| cm_wr_chan | input | 7 | Output channel whose entry is written |
| cm_wr_src | input | 7 | Source input channel for that output |
| cm_wr_const | input | 1 | Delay mode: 1 constant, 0 variable |
| slot_idx | output | 7 | Current time slot |
| out_byte | output | 8 | Byte of the output channel equal to the current slot |

## Verification
The bench goes after the variable-mode boundaries at m = n+2 and m = n+3, and after pairs that wrap across the frame edge (for example a late source feeding output slots 0 and 1):
- A core with the wrong freshness compare would send stale data one frame late, or leak a byte before it was stored.

Constant-mode channels mixed with variable ones check the two-frame bank offset:
- An off-by-one bank would deliver data one frame early or late, or read a bank still being filled.

A remap issued partway through a frame, including writes in the last three slots, checks that the table swap happens at the frame boundary:
- An early or late swap would switch part of a frame with the wrong map.

A frame pulse arriving mid-frame checks the forced restart:
- A core that ignored the pulse would keep counting from the old slot.

// File: rtl/tsi_pkg.sv
// Package: shared constants, rate encoding and bank rotation helpers for
// the time-slot interchange core. Assumes exactly three data banks.
package tsi_pkg;

    localparam int TSI_MAX_CH = 128;
    localparam int TSI_DATA_W = 8;
    localparam int TSI_BANKS  = 3;

    typedef enum logic [1:0] {
        RATE_QUARTER = 2'd0,
        RATE_HALF    = 2'd1,
        RATE_FULL    = 2'd2,
        RATE_FULL_B  = 2'd3
    } rate_e;

    typedef logic [1:0] bank_t;

    // Next bank in the 0,1,2 rotation.
    function automatic bank_t bank_next(bank_t b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    // Previous bank in the 0,1,2 rotation.
    function automatic bank_t bank_prev(bank_t b);
        return (b == 2'd0) ? 2'd2 : b - 2'd1;
    endfunction

    // Right shift applied to the largest frame to obtain the selected one.
    function automatic int frame_shift(logic [1:0] rate);
        case (rate)
            RATE_QUARTER: return 2;
            RATE_HALF:    return 1;
            default:      return 0;
        endcase
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
// Slot timer: counts time slots within a frame, rotates the write bank
// at each frame start and flags the slot at which the connection map is
// loaded. Assumes rate_sel only changes while in reset and MAX_CH is a
// power of two of at least 8.
module tsi_slot_timer
    import tsi_pkg::*;
#(
    parameter int  MAX_CH = TSI_MAX_CH,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int LW     = CH_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      rate_sel,
    input  logic            frame_pulse,
    output logic [CH_W-1:0] slot,
    output logic [CH_W-1:0] last_slot,
    output bank_t           wr_bank,
    output logic            map_load
);

    logic [LW-1:0] frame_len;
    logic          frame_end;

    // Frame length from the rate selection.
    assign frame_len = LW'(MAX_CH) >> frame_shift(rate_sel);
    assign last_slot = CH_W'(frame_len - LW'(1));
    assign frame_end = frame_pulse || (slot == last_slot);

    // Map load strobe on the last slot whose fetch targets this frame.
    assign map_load  = (slot == last_slot - CH_W'(2));

    // Slot counter with wrap and forced restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (frame_end) begin
            slot <= '0;
        end else begin
            slot <= slot + CH_W'(1);
        end
    end

    // Write bank rotation, one step per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 2'd0;
        end else if (frame_end) begin
            wr_bank <= bank_next(wr_bank);
        end
    end

endmodule

// File: rtl/tsi_conn_mem.sv
// Connection memory: a host-written shadow table and a live table read
// by the fetch logic. The shadow is copied whole into the live table on
// the load strobe, so the live map never changes within an output frame.
module tsi_conn_mem #(
    parameter int  MAX_CH = 128,
    localparam int CH_W   = $clog2(MAX_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [CH_W-1:0] wr_src,
    input  logic            wr_const,
    input  logic            load,
    input  logic [CH_W-1:0] rd_chan,
    output logic [CH_W-1:0] rd_src,
    output logic            rd_const
);

    logic [CH_W-1:0] shadow_src   [MAX_CH];
    logic            shadow_const [MAX_CH];
    logic [CH_W-1:0] live_src     [MAX_CH];
    logic            live_const   [MAX_CH];

    // Host writes land in the shadow table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_CH; i++) begin
                shadow_src[i]   <= '0;
                shadow_const[i] <= 1'b0;
            end
        end else if (wr_en) begin
            shadow_src[wr_chan]   <= wr_src;
            shadow_const[wr_chan] <= wr_const;
        end
    end

    // Whole-table transfer into service once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_CH; i++) begin
                live_src[i]   <= '0;
                live_const[i] <= 1'b0;
            end
        end else if (load) begin
            for (int i = 0; i < MAX_CH; i++) begin
                live_src[i]   <= shadow_src[i];
                live_const[i] <= shadow_const[i];
            end
        end
    end

    // Asynchronous read of the live entry for the fetch target.
    assign rd_src   = live_src[rd_chan];
    assign rd_const = live_const[rd_chan];

endmodule

// File: rtl/tsi_data_mem.sv
// Banked data memory: one bank per frame in rotation. Each slot writes
// the incoming byte into the current bank at the slot address; reads are
// asynchronous from any bank. Contents are cleared by reset.
module tsi_data_mem #(
    parameter int  MAX_CH = 128,
    parameter int  DATA_W = 8,
    parameter int  BANKS  = 3,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int BK_W   = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BK_W-1:0]   wr_bank,
    input  logic [CH_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BK_W-1:0]   rd_bank,
    input  logic [CH_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] cells [MAX_CH];

        // Store the slot byte when this bank is the write bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < MAX_CH; i++) begin
                    cells[i] <= '0;
                end
            end else if (wr_bank == BK_W'(b)) begin
                cells[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[b] = cells[rd_addr];
    end

    // Select the addressed bank.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_bank == BK_W'(b)) begin
                rd_data = bank_rd[b];
            end
        end
    end

endmodule

// File: rtl/tsi_core.sv
// Time-slot interchange core top. Each slot, it looks up the connection
// entry of the output slot two ahead, picks the bank holding the wanted
// copy of the source byte and reads it. Two pipeline registers then put
// the byte out in its own slot. Assumes one slot per clock and a static
// rate_sel outside reset.
module tsi_core
    import tsi_pkg::*;
#(
    parameter int  MAX_CH = TSI_MAX_CH,
    parameter int  DATA_W = TSI_DATA_W,
    localparam int CH_W   = $clog2(MAX_CH),
    localparam int AW     = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              frame_pulse,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              cm_wr_en,
    input  logic [CH_W-1:0]   cm_wr_chan,
    input  logic [CH_W-1:0]   cm_wr_src,
    input  logic              cm_wr_const,
    output logic [CH_W-1:0]   slot_idx,
    output logic [DATA_W-1:0] out_byte
);

    logic [CH_W-1:0]   slot;
    logic [CH_W-1:0]   last_slot;
    bank_t             wr_bank;
    logic              map_load;
    logic [AW-1:0]     ahead;
    logic              fetch_wraps;
    logic [CH_W-1:0]   fetch_chan;
    logic [CH_W-1:0]   cm_src;
    logic              cm_const;
    bank_t             var_bank;
    bank_t             fixed_bank;
    bank_t             rd_bank;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] fetch_q;
    logic [DATA_W-1:0] out_q;

    tsi_slot_timer #(.MAX_CH(MAX_CH)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .frame_pulse (frame_pulse),
        .slot        (slot),
        .last_slot   (last_slot),
        .wr_bank     (wr_bank),
        .map_load    (map_load)
    );

    // Output slot served by this cycle's fetch, two slots ahead.
    assign ahead       = {1'b0, slot} + AW'(2);
    assign fetch_wraps = ahead > {1'b0, last_slot};
    assign fetch_chan  = fetch_wraps ? CH_W'(ahead - {1'b0, last_slot} - AW'(1))
                                     : ahead[CH_W-1:0];

    tsi_conn_mem #(.MAX_CH(MAX_CH)) u_cmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cm_wr_en),
        .wr_chan  (cm_wr_chan),
        .wr_src   (cm_wr_src),
        .wr_const (cm_wr_const),
        .load     (map_load),
        .rd_chan  (fetch_chan),
        .rd_src   (cm_src),
        .rd_const (cm_const)
    );

    // Bank choice: newest stored copy, or the copy two output frames old.
    always_comb begin
        var_bank   = (cm_src < slot) ? wr_bank : bank_prev(wr_bank);
        fixed_bank = fetch_wraps ? bank_prev(wr_bank) : bank_next(wr_bank);
        rd_bank    = cm_const ? fixed_bank : var_bank;
    end

    tsi_data_mem #(
        .MAX_CH (MAX_CH),
        .DATA_W (DATA_W),
        .BANKS  (TSI_BANKS)
    ) u_dmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_bank (wr_bank),
        .wr_addr (slot),
        .wr_data (in_byte),
        .rd_bank (rd_bank),
        .rd_addr (cm_src),
        .rd_data (rd_data)
    );

    // Two-stage output pipeline aligning the fetched byte with its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
            out_q   <= '0;
        end else begin
            fetch_q <= rd_data;
            out_q   <= fetch_q;
        end
    end

    assign slot_idx = slot;
    assign out_byte = out_q;

endmodule

// File: rtl/tsi_core_chk.sv
// Checker for tsi_core: slot sequencing, frame restart, bank rotation and
// reset output state. Attached to every tsi_core instance by bind.
module tsi_core_chk
    import tsi_pkg::*;
#(
    parameter int  MAX_CH = TSI_MAX_CH,
    parameter int  DATA_W = TSI_DATA_W,
    localparam int CH_W   = $clog2(MAX_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        rate_sel,
    input logic              frame_pulse,
    input logic [CH_W-1:0]   slot_idx,
    input logic [DATA_W-1:0] out_byte,
    input logic [1:0]        wr_bank
);

    logic [CH_W-1:0] chk_last;

    // Expected last slot per rate.
    always_comb begin
        case (rate_sel)
            2'd0:    chk_last = CH_W'(MAX_CH / 4 - 1);
            2'd1:    chk_last = CH_W'(MAX_CH / 2 - 1);
            default: chk_last = CH_W'(MAX_CH - 1);
        endcase
    end

    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= chk_last); // R1
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && slot_idx != chk_last) |=> slot_idx == $past(slot_idx) + CH_W'(1)); // R1
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && slot_idx == chk_last) |=> slot_idx == '0); // R1
    AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> slot_idx == '0); // R8
    AST_BANK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse || slot_idx == chk_last) |=> wr_bank == bank_next($past(wr_bank))); // R8
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse && slot_idx != chk_last) |=> $stable(wr_bank)); // R6
    AST_BANK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bank != 2'd3); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_byte == '0 && slot_idx == '0)); // R2

endmodule

bind tsi_core tsi_core_chk #(.MAX_CH(MAX_CH), .DATA_W(DATA_W)) u_tsi_core_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .frame_pulse (frame_pulse),
    .slot_idx    (slot_idx),
    .out_byte    (out_byte),
    .wr_bank     (wr_bank)
);

// File: tb/test_tsi_core.sv
// Directed bench for tsi_core. A reference model built from the
// requirements predicts every output byte from the input pattern and
// the connection map in force for each output frame.
module test_tsi_core;

    logic       clk;
    logic       rst_n;
    logic [1:0] rate_sel;
    logic       frame_pulse;
    logic [7:0] in_byte;
    logic       cm_wr_en;
    logic [6:0] cm_wr_chan;
    logic [6:0] cm_wr_src;
    logic       cm_wr_const;
    logic [6:0] slot_idx;
    logic [7:0] out_byte;

    tsi_core i_tsi_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .frame_pulse (frame_pulse),
        .in_byte     (in_byte),
        .cm_wr_en    (cm_wr_en),
        .cm_wr_chan  (cm_wr_chan),
        .cm_wr_src   (cm_wr_src),
        .cm_wr_const (cm_wr_const),
        .slot_idx    (slot_idx),
        .out_byte    (out_byte)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    int    n_ch   = 32;
    int    abs_c  = 0;
    string tag_pre = "";
    bit    done   = 0;

    int sh_src [128];
    bit sh_c   [128];
    int pd_src [128];
    bit pd_c   [128];
    int cu_src [128];
    bit cu_c   [128];

    function automatic logic [7:0] pat(int a);
        return 8'(a * 29 + (a >> 4) * 7 + 3);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (abs slot %0d)", req, act, exp, abs_c);
        end
    endtask

    // Reset with a rate; leaves the bench at a falling edge, reset released.
    task automatic do_reset(logic [1:0] rate);
        rst_n = 1'b0; rate_sel = rate; frame_pulse = 1'b0; in_byte = '0;
        cm_wr_en = 1'b0; cm_wr_chan = '0; cm_wr_src = '0; cm_wr_const = 1'b0;
        repeat (3) @(negedge clk);
        check(slot_idx == 7'd0, "R2", int'(slot_idx), 0);
        check(out_byte == 8'd0, "R2", int'(out_byte), 0);
        n_ch = (rate == 2'd0) ? 32 : (rate == 2'd1) ? 64 : 128;
        for (int i = 0; i < 128; i++) begin
            sh_src[i] = 0; sh_c[i] = 0; pd_src[i] = 0; pd_c[i] = 0; cu_src[i] = 0; cu_c[i] = 0;
        end
        abs_c = 0;
        tag_pre = "";
        rst_n = 1'b1;
    endtask

    // One slot: check outputs against the model, then drive this slot's inputs.
    task automatic step(bit we, int ch, int src, bit cmode);
        int m; int n; int d; int dd; int e; string req;
        m = abs_c % n_ch;
        if (m == 0 && abs_c > 0) begin
            cu_src = pd_src; cu_c = pd_c;
        end
        check(slot_idx == 7'(m), "R1", int'(slot_idx), m);
        n = cu_src[m];
        if (cu_c[m]) begin
            d = 2 * n_ch + m - n;
            req = "R6";
        end else begin
            dd = ((m - n) % n_ch + n_ch) % n_ch;
            if (m >= n + 3)  req = "R3";
            else if (m >= n) req = "R4";
            else             req = "R5";
            d = (dd < 3) ? dd + n_ch : dd;
        end
        e = (abs_c - d >= 0) ? int'(pat(abs_c - d)) : 0;
        check(out_byte == 8'(e), {tag_pre, req}, int'(out_byte), e);
        if (m == n_ch - 3) begin
            pd_src = sh_src; pd_c = sh_c;
        end
        if (we) begin
            sh_src[ch] = src; sh_c[ch] = cmode;
        end
        in_byte = pat(abs_c);
        cm_wr_en = we; cm_wr_chan = 7'(ch); cm_wr_src = 7'(src); cm_wr_const = cmode;
        abs_c++;
        @(negedge clk);
    endtask

    task automatic run_slots(int cnt);
        for (int i = 0; i < cnt; i++) step(1'b0, 0, 0, 1'b0);
    endtask

    // R4: identity map in variable mode, one frame of delay everywhere.
    task automatic t_var_identity();
        do_reset(2'd0);
        for (int c = 0; c < n_ch; c++) step(1'b1, c, c, 1'b0);
        run_slots(4 * n_ch);
    endtask

    // R3/R5: spread map in variable mode covering all source/target orders.
    task automatic t_var_spread();
        do_reset(2'd1);
        for (int c = 0; c < n_ch; c++) step(1'b1, c, (c * 5 + 7) % n_ch, 1'b0);
        run_slots(4 * n_ch);
    endtask

    // R6: constant mode on even outputs mixed with variable on odd outputs.
    task automatic t_const_mix();
        do_reset(2'd2);
        for (int c = 0; c < n_ch; c++) step(1'b1, c, (c * 3 + 1) % n_ch, (c % 2) == 0);
        run_slots(4 * n_ch);
    endtask

    // R7: remap while traffic flows; late writes must slip a frame.
    task automatic t_remap();
        tag_pre = "R7 ";
        for (int c = 0; c < n_ch; c++) step(1'b1, c, n_ch - 1 - c, 1'b1);
        run_slots(3 * n_ch);
        for (int c = 0; c < n_ch; c++) step(1'b1, c, (c + 2) % n_ch, 1'b0);
        run_slots(3 * n_ch);
        tag_pre = "";
    endtask

    // R1: rate code 3 behaves as the 128-slot frame; wrap cases to outputs 0/1.
    task automatic t_rate_alt();
        do_reset(2'd3);
        for (int c = 0; c < n_ch; c++) step(1'b1, c, (c + 126) % n_ch, 1'b0);
        run_slots(3 * n_ch);
    endtask

    // R8: frame pulse mid-frame restarts slot count; R1 wrap afterwards.
    task automatic t_frame_pulse();
        do_reset(2'd0);
        run_slots(40);
        cm_wr_en = 1'b0;
        while (slot_idx != 7'd10) @(negedge clk);
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
        check(slot_idx == 7'd0, "R8", int'(slot_idx), 0);
        repeat (31) @(negedge clk);
        check(slot_idx == 7'd31, "R1", int'(slot_idx), 31);
        @(negedge clk);
        check(slot_idx == 7'd0, "R1", int'(slot_idx), 0);
    endtask

    initial begin
        rst_n = 1'b0;
        t_var_identity();
        t_var_spread();
        t_const_mix();
        t_remap();
        t_rate_alt();
        t_frame_pulse();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule